// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block sits on the host side of a byte-wide flash device. Once a program or erase command has been issued elsewhere, a pulse on `start` makes the controller read a fixed address over and over. From the status bits it decides whether the operation finished, failed, or never answered. It has two methods. Data polling compares bit 7 of each read with bit 7 of the expected byte; after an erase the caller passes an expected byte with bit 7 set. Toggle polling compares bit 6 of two reads in a row.

Bit 5 of a status read reports that the device ran out of internal attempts. The status bits can settle before the rest of the byte, so a single read with bit 5 set is not enough to decide. The controller then makes exactly one more read. If the completion condition holds on that read, the operation passed. If it does not, the operation failed, and the controller also raises a request that the device be reset. A programmable read budget stops the controller from waiting forever on a device that never responds.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset, `rd_req`, `done`, `pass`, `fail` and `reset_req` are all 0.
- R2: A `start` seen while idle latches `addr_in`. `rd_addr` then carries that value for the whole operation, whatever `addr_in` does afterwards.
- R3: `rd_req` stays high from the cycle after an accepted `start` until the final read is acknowledged. Each cycle with `rd_ack` high consumes exactly one byte from `rd_data`.
- R4: With `mode` = 0 (data polling), a read completes the operation when its bit 7 equals bit 7 of `exp_data`.
- R5: With `mode` = 1 (toggle polling), a read completes the operation when its bit 6 equals bit 6 of the previous read of the same operation. The first read never completes.
- R6: A read that does not complete but has bit 5 set triggers exactly one confirming read, even if the budget is used up. If that confirming read completes, the result is pass.
- R7: If the confirming read does not complete, the result is fail and `reset_req` is 1.
- R8: Ordinary reads are limited to `max_polls`, with 0 treated as 1. When the last allowed read neither completes nor has bit 5 set, the result is fail with `reset_req` 0. A read that completes is never counted as a failure.
- R9: `done` is high for exactly one cycle, in the cycle after the final `rd_ack`. `pass`, `fail` and `reset_req` take their values in that same cycle and hold them until the next accepted `start`.
- R10: `start` is ignored while an operation is in progress. It does not change the address, the number of reads or the result, and it does not launch a second operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin polling (accepted only when idle) |
| mode | input | 1 | 0 = data polling on bit 7, 1 = toggle polling on bit 6 |
| exp_data | input | 8 | Expected byte; only bit 7 is used |
| addr_in | input | AW | Address to poll |
| max_polls | input | CW | Read budget; 0 means 1 |
| rd_req | output | 1 | Read request toward the device |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read data valid; completes one read |
| rd_data | input | 8 | Byte returned by the device |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation succeeded |
| fail | output | 1 | Operation failed or timed out |
| reset_req | output | 1 | Device must be reset (bit 5 confirmed) |

## Verification
`rd_req` rises one cycle after `start` is sampled. `done` and the result flags change one cycle after the edge that samples the final `rd_ack`. The bench drives each acknowledge at a falling edge and reads the outputs at the next falling edge, so every sample lands one register stage after its cause. For each case, the bench works out in advance, from the scripted byte sequence, the number of reads, the verdict and `reset_req`. It then checks that `done` falls in the following cycle and that the flags and an idle `rd_req` hold for several more cycles.

// File: rtl/flash_poll_pkg.sv
// Shared types for the flash completion polling controller.
// Assumes status bit positions fixed by the device: 7 data, 6 toggle, 5 limit.
package flash_poll_pkg;
    typedef enum logic {
        MODE_DATA   = 1'b0,
        MODE_TOGGLE = 1'b1
    } poll_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_POLL    = 2'd1,
        ST_CONFIRM = 2'd2
    } poll_state_t;

    localparam int BIT_DATA   = 7;
    localparam int BIT_TOGGLE = 6;
    localparam int BIT_LIMIT  = 5;
endpackage

// File: rtl/poll_judge.sv
// Evaluates one returned status byte against the completion rule of the
// selected mode. Keeps the toggle bit of the previous read of the operation.
// Assumes clear is pulsed when an operation starts and capture on every read.
module poll_judge
    import flash_poll_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       capture,
    input  poll_mode_t mode,
    input  logic       exp_bit,
    input  logic [7:0] rd_data,
    output logic       complete,
    output logic       limit_flag
);
    logic prev_tog;
    logic have_prev;

    // Remember bit 6 of the most recent read for the toggle comparison.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            prev_tog  <= 1'b0;
            have_prev <= 1'b0;
        end else if (capture) begin
            prev_tog  <= rd_data[BIT_TOGGLE];
            have_prev <= 1'b1;
        end
    end

    // Apply the completion rule for the current mode.
    always_comb begin
        if (mode == MODE_DATA)
            complete = (rd_data[BIT_DATA] == exp_bit);
        else
            complete = have_prev && (rd_data[BIT_TOGGLE] == prev_tog);
        limit_flag = rd_data[BIT_LIMIT];
    end

    // R5
    prev_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(have_prev) |-> $past(capture));
endmodule

// File: rtl/poll_budget.sv
// Counts ordinary polling reads against a limit latched at start.
// A limit of zero behaves as one. Assumes step is never raised on the last read.
module poll_budget #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] limit,
    input  logic          step,
    output logic          last
);
    logic [CW-1:0] limit_q;
    logic [CW-1:0] count_q;
    logic [CW-1:0] eff;

    // Latch the limit and clear the count at start; advance on each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '0;
            count_q <= '0;
        end else if (load) begin
            limit_q <= limit;
            count_q <= '0;
        end else if (step) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Flag the read that uses the final slot of the budget.
    always_comb begin
        eff  = (limit_q == '0) ? CW'(1) : limit_q;
        last = ({1'b0, count_q} + 1'b1) >= {1'b0, eff};
    end

    // R8
    budget_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q < eff);
endmodule

// File: rtl/flash_poll_ctrl.sv
// Host-side controller that polls a flash device until a program or erase
// finishes and reports pass or fail. Assumes a read handshake in which rd_ack
// comes with valid rd_data while rd_req is high, one byte per ack cycle.
module flash_poll_ctrl
    import flash_poll_pkg::*;
#(
    parameter int AW = 19,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode,
    input  logic [7:0]    exp_data,
    input  logic [AW-1:0] addr_in,
    input  logic [CW-1:0] max_polls,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [7:0]    rd_data,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic          reset_req
);
    poll_state_t   state;
    poll_mode_t    mode_q;
    logic          exp_q;
    logic [AW-1:0] addr_q;
    logic          complete;
    logic          limit_flag;
    logic          last;
    logic          accept;
    logic          poll_ack;
    logic          step;

    // Decode handshake events used by the helpers.
    always_comb begin
        accept   = (state == ST_IDLE) && start;
        poll_ack = (state == ST_POLL) && rd_ack;
        step     = poll_ack && !complete && !limit_flag && !last;
        rd_req   = (state != ST_IDLE);
        rd_addr  = addr_q;
    end

    poll_judge u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .capture    (rd_ack && (state != ST_IDLE)),
        .mode       (mode_q),
        .exp_bit    (exp_q),
        .rd_data    (rd_data),
        .complete   (complete),
        .limit_flag (limit_flag)
    );

    poll_budget #(.CW(CW)) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .limit (max_polls),
        .step  (step),
        .last  (last)
    );

    // Sequence the operation and register the verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mode_q    <= MODE_DATA;
            exp_q     <= 1'b0;
            addr_q    <= '0;
            done      <= 1'b0;
            pass      <= 1'b0;
            fail      <= 1'b0;
            reset_req <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    state     <= ST_POLL;
                    mode_q    <= poll_mode_t'(mode);
                    exp_q     <= exp_data[BIT_DATA];
                    addr_q    <= addr_in;
                    pass      <= 1'b0;
                    fail      <= 1'b0;
                    reset_req <= 1'b0;
                end
                ST_POLL: if (rd_ack) begin
                    if (complete) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        pass  <= 1'b1;
                    end else if (limit_flag) begin
                        state <= ST_CONFIRM;
                    end else if (last) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        fail  <= 1'b1;
                    end
                end
                ST_CONFIRM: if (rd_ack) begin
                    state     <= ST_IDLE;
                    done      <= 1'b1;
                    pass      <= complete;
                    fail      <= !complete;
                    reset_req <= !complete;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));

    // R7
    reset_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> fail);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && $past(rd_req)) |-> $stable(rd_addr));

    // R3
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(rd_ack) && $past(rd_req)));
endmodule

// File: tb/flash_poll_ctrl_test.sv
module flash_poll_ctrl_test;
    localparam int AW = 4;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic [7:0]    exp_data = '0;
    logic [AW-1:0] addr_in = '0;
    logic [CW-1:0] max_polls = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [7:0]    rd_data = '0;
    logic          done, pass, fail, reset_req;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // scenario
    int fin_at;
    int fa_at;
    logic e7;

    flash_poll_ctrl #(.AW(AW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .exp_data(exp_data), .addr_in(addr_in), .max_polls(max_polls),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .done(done), .pass(pass), .fail(fail), .reset_req(reset_req)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    function automatic logic [7:0] dev_byte(input int k);
        logic [7:0] b;
        int f1;
        f1 = fin_at - 1;
        b[4:0] = 5'(k) ^ 5'h0a;
        b[7] = (k >= fin_at) ? e7 : ~e7;
        b[6] = (k < fin_at) ? k[0] : f1[0];
        b[5] = (k >= fa_at);
        return b;
    endfunction

    task automatic run_case(input bit md, input int fin, input int fa,
                            input int lim, input int lat, input logic [AW-1:0] a);
        int leff, exp_reads, reads, waitc, guard, done_cnt;
        bit exp_pass, exp_rr, seen;
        logic p_s, f_s, r_s;
        fin_at = fin; fa_at = fa; e7 = fin[1];
        leff = (lim == 0) ? 1 : lim;
        if (fa < fin && fa < leff) begin
            exp_reads = fa + 2; exp_pass = (fa + 1 >= fin); exp_rr = !exp_pass;
        end else if (fin < leff) begin
            exp_reads = fin + 1; exp_pass = 1'b1; exp_rr = 1'b0;
        end else begin
            exp_reads = leff; exp_pass = 1'b0; exp_rr = 1'b0;
        end
        @(negedge clk);
        mode = md; exp_data = {e7, 7'h35}; addr_in = a; max_polls = CW'(lim);
        start = 1'b1;
        reads = 0; waitc = 0; guard = 0; seen = 1'b0;
        @(negedge clk);
        // R10: a second start while busy, with a different address
        start = 1'b1; addr_in = ~a;
        while (!seen && guard < 100) begin
            guard++;
            if (done) begin
                seen = 1'b1;
            end else begin
                // R2
                if (rd_req) check(rd_addr == a, "R2", "rd_addr", int'(rd_addr), int'(a));
                if (rd_req && waitc == lat) begin
                    rd_ack = 1'b1; rd_data = dev_byte(reads); reads++; waitc = 0;
                end else begin
                    rd_ack = 1'b0; rd_data = 8'hxx === 8'hxx ? 8'h00 : 8'h00;
                    if (rd_req) waitc++;
                end
                @(negedge clk);
                start = 1'b0;
            end
        end
        rd_ack = 1'b0;
        check(seen, "R3", "done seen", int'(seen), 1);
        // R4 R5 R6 R8
        check(pass == exp_pass, md ? "R5" : "R4", "pass", int'(pass), int'(exp_pass));
        check(fail == !exp_pass, "R8", "fail", int'(fail), int'(!exp_pass));
        // R7
        check(reset_req == exp_rr, "R7", "reset_req", int'(reset_req), int'(exp_rr));
        // R6 R8 read count
        check(reads == exp_reads, "R6", "reads", reads, exp_reads);
        p_s = pass; f_s = fail; r_s = reset_req;
        done_cnt = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (done) done_cnt++;
            // R10: no second operation launched
            check(!rd_req, "R10", "rd_req idle", int'(rd_req), 0);
        end
        // R9
        check(done_cnt == 0, "R9", "done width", done_cnt + 1, 1);
        check(pass == p_s && fail == f_s && reset_req == r_s, "R9", "flags held",
              int'({pass, fail, reset_req}), int'({p_s, f_s, r_s}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(!rd_req && !done && !pass && !fail && !reset_req, "R1", "reset outputs",
              int'({rd_req, done, pass, fail, reset_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rd_req && !done, "R1", "idle after reset", int'({rd_req, done}), 0);
        for (int md = 0; md < 2; md++)
            for (int fin = 1; fin <= 5; fin++)
                for (int fa = 1; fa <= 7; fa++)
                    for (int lim = 0; lim <= 6; lim++)
                        for (int lat = 0; lat < 2; lat++)
                            run_case(md[0], fin, (fa == 7) ? 99 : fa, lim, lat,
                                     AW'(fin * 3 + lim));
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule